// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block watches the command bus of a two-bank synchronous DRAM and judges every command against the state of the bank it addresses. On each rising clock edge it samples chip select, the three strobes, clock enable and the address pins. It decodes the command and updates one state tracker per bank. Each tracker knows whether its bank is idle, has an open row, is in a read or write burst, or is precharging. A command that the current state forbids is reported as a one-cycle error pulse with a code saying which rule was broken. The illegal command is then ignored by the trackers.

The checker sits beside a memory controller in simulation or in silicon debug logic. It never drives the memory bus. The activate-to-access delay, the activate-to-precharge delay, the precharge duration and the burst length are whole clock cycles fixed at elaboration. Rules that involve both banks are checked in the same cycle as the per-bank rules: refresh, mode-register load, self-refresh and power-down each need both banks idle.

The decoded command, the error pulse and its code are registered. They appear in the cycle after the edge that sampled the command. The bank state outputs show each tracker's register after that same edge.

Top module: `sdram_cmd_guard`

## Requirements
- R1: When chip select is high the command is a deselect (code 0) and no bank changes state. With CKE high and chip select low, the pins {ras_n,cas_n,we_n} decode as follows: 011 activate (1), 101 read (2, or 3 with auto-precharge bit high), 100 write (4, or 5 with the bit high), 010 precharge (6, or 7 for both banks with the bit high), 001 refresh (8), 000 mode load (10), 110 burst stop (11) and 111 no operation (0). Each code appears on `cmd_code_o` one cycle after it is sampled.
- R2: Bank states are encoded as idle 0, row open 1, reading 2, writing 3 and precharging 4. The top address bit selects the bank and the bit below it is the auto-precharge / all-banks flag. An activate to an idle bank opens it with no error.
- R3: An activate to a bank whose row is open, or which is bursting, raises error code 1, and the bank state is unchanged.
- R4: A read or write to an idle bank raises error code 2, and the bank stays idle.
- R5: A read or write issued fewer than T_RCD cycles after the bank's activate raises error code 3 and is ignored. At exactly T_RCD cycles it is accepted.
- R6: A precharge issued fewer than T_RAS cycles after the bank's activate raises error code 3+1 (4) and is ignored. An accepted precharge moves the bank to precharging. A precharge with the all-banks flag acts on both banks, and a precharge to an idle bank has no effect and raises no error.
- R7: After a precharge a bank reports precharging for T_RP cycles and then idle. An activate, read or write in those cycles raises error code 5. An activate at exactly T_RP cycles is accepted.
- R8: A burst keeps the bank reading or writing for BURST_LEN cycles, then returns it to row open. With auto-precharge it goes instead to precharging for T_RP cycles and then to idle. A burst stop returns a bursting bank to row open at once.
- R9: CKE falling outside the self-refresh pattern is reported as code 12. It is legal when both banks are idle (power-down) or when a bank is bursting (clock suspend); otherwise it raises error code 6. While CKE is low, no bank state or timer moves and no command is decoded.
- R10: Self-refresh entry (chip select, RAS and CAS low, WE high, CKE falling; code 9), refresh and mode load each need both banks idle. Otherwise they raise error code 7, 8 and 9 respectively.
- R11: `err_o` is high for exactly one cycle per illegal command, always with a nonzero code. It is low with code 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, rising edge samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| addr | input | ADDR_W | Address pins; top bit bank, next bit auto-precharge / all-banks |
| cmd_code_o | output | 4 | Decoded command of the previous edge |
| err_o | output | 1 | One-cycle illegal-command pulse |
| err_code_o | output | 4 | Rule broken by that command, 0 when none |
| bank0_state_o | output | 3 | State of bank 0 |
| bank1_state_o | output | 3 | State of bank 1 |

## Verification
A tracker that holds a wrong state shows it at once on its state output, one cycle after the command that moved it. It also shows within a few cycles as a false or missing error pulse when the next command reaches that bank. A timer that is off by one cycle only shows at the boundary cycle. For that reason the directed scenarios put a command one cycle before and exactly at each T_RCD, T_RAS and T_RP limit, and they count burst cycles through a clock suspend. There the frozen timer must resume with the same count left.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_ACT  = 4'd1,
      CMD_RD   = 4'd2,
      CMD_RDA  = 4'd3,
      CMD_WR   = 4'd4,
      CMD_WRA  = 4'd5,
      CMD_PRE  = 4'd6,
      CMD_PALL = 4'd7,
      CMD_REF  = 4'd8,
      CMD_SREF = 4'd9,
      CMD_MRS  = 4'd10,
      CMD_BST  = 4'd11,
      CMD_PDN  = 4'd12
   } cmd_e;

   typedef enum logic [2:0] {
      BK_IDLE   = 3'd0,
      BK_ACTIVE = 3'd1,
      BK_READ   = 3'd2,
      BK_WRITE  = 3'd3,
      BK_PRECH  = 3'd4
   } bank_e;

   typedef enum logic [3:0] {
      ERR_NONE     = 4'd0,
      ERR_ACT_OPEN = 4'd1,
      ERR_IDLE_RW  = 4'd2,
      ERR_RCD      = 4'd3,
      ERR_RAS      = 4'd4,
      ERR_BUSY     = 4'd5,
      ERR_PDN      = 4'd6,
      ERR_SREF     = 4'd7,
      ERR_REF      = 4'd8,
      ERR_MRS      = 4'd9
   } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_guard_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic cke,
   input  logic cke_q,
   input  logic ap,
   output cmd_e cmd
);

   always_comb begin
      cmd = CMD_NOP;
      if (cke_q && !cke) begin
         // falling clock enable: self-refresh pattern or power-down / suspend
         if (!cs_n && !ras_n && !cas_n && we_n) cmd = CMD_SREF;
         else                                   cmd = CMD_PDN;
      end else if (cke && !cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = ap ? CMD_RDA  : CMD_RD;
            3'b100:  cmd = ap ? CMD_WRA  : CMD_WR;
            3'b010:  cmd = ap ? CMD_PALL : CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
   import sdram_guard_pkg::*;
#(
   parameter int T_RCD     = 2,
   parameter int T_RAS     = 4,
   parameter int T_RP      = 2,
   parameter int BURST_LEN = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  advance,
   input  logic  hit,
   input  cmd_e  cmd,
   output bank_e state_o,
   output err_e  err_o,
   output logic  idle_o,
   output logic  burst_o
);

   localparam int MAX_A = (T_RCD > T_RAS) ? T_RCD : T_RAS;
   localparam int MAX_B = (T_RP > BURST_LEN) ? T_RP : BURST_LEN;
   localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = $clog2(MAXV + 1);

   initial begin
      assert (T_RCD >= 1 && T_RAS >= 1 && T_RP >= 1 && BURST_LEN >= 1)
         else $error("bank tracker: every timing parameter must be at least 1");
   end

   bank_e            state;
   logic [CNT_W-1:0] rcd_cnt, ras_cnt, gp_cnt;
   logic             ap_q;
   logic             is_act, is_rw, is_pre, is_open, prech_busy;
   err_e             err;

   assign is_act     = (cmd == CMD_ACT);
   assign is_rw      = (cmd == CMD_RD) || (cmd == CMD_RDA) || (cmd == CMD_WR) || (cmd == CMD_WRA);
   assign is_pre     = (cmd == CMD_PRE) || (cmd == CMD_PALL);
   assign is_open    = (state == BK_ACTIVE) || (state == BK_READ) || (state == BK_WRITE);
   assign prech_busy = (state == BK_PRECH) && (gp_cnt != '0);
   assign idle_o     = (state == BK_IDLE) || ((state == BK_PRECH) && (gp_cnt == '0));
   assign burst_o    = (state == BK_READ) || (state == BK_WRITE);
   assign state_o    = state;
   assign err_o      = err;

   always_comb begin
      err = ERR_NONE;
      if (hit && advance) begin
         if (is_act) begin
            if (prech_busy)   err = ERR_BUSY;
            else if (is_open) err = ERR_ACT_OPEN;
         end else if (is_rw) begin
            if (prech_busy)             err = ERR_BUSY;
            else if (idle_o)            err = ERR_IDLE_RW;
            else if (rcd_cnt != '0)     err = ERR_RCD;
         end else if (is_pre) begin
            if (is_open && ras_cnt != '0) err = ERR_RAS;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= BK_IDLE;
         rcd_cnt <= '0;
         ras_cnt <= '0;
         gp_cnt  <= '0;
         ap_q    <= 1'b0;
      end else if (advance) begin
         if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
         if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
         if (gp_cnt  != '0) gp_cnt  <= gp_cnt  - 1'b1;
         if (hit && err == ERR_NONE && is_act && idle_o) begin
            state   <= BK_ACTIVE;
            rcd_cnt <= CNT_W'(T_RCD - 1);
            ras_cnt <= CNT_W'(T_RAS - 1);
         end else if (hit && err == ERR_NONE && is_rw && is_open) begin
            state  <= ((cmd == CMD_RD) || (cmd == CMD_RDA)) ? BK_READ : BK_WRITE;
            gp_cnt <= CNT_W'(BURST_LEN - 1);
            ap_q   <= (cmd == CMD_RDA) || (cmd == CMD_WRA);
         end else if (hit && err == ERR_NONE && is_pre && is_open) begin
            state  <= BK_PRECH;
            gp_cnt <= CNT_W'(T_RP - 1);
         end else if (hit && cmd == CMD_BST && burst_o) begin
            state <= BK_ACTIVE;
         end else if (burst_o && gp_cnt == '0) begin
            if (ap_q) begin
               state  <= BK_PRECH;
               gp_cnt <= CNT_W'(T_RP - 1);
            end else begin
               state <= BK_ACTIVE;
            end
         end else if (state == BK_PRECH && gp_cnt == '0) begin
            state <= BK_IDLE;
         end
      end
   end

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
   import sdram_guard_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int T_RCD     = 2,
   parameter int T_RAS     = 4,
   parameter int T_RP      = 2,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              cke,
   input  logic [ADDR_W-1:0] addr,
   output logic [3:0]        cmd_code_o,
   output logic              err_o,
   output logic [3:0]        err_code_o,
   output logic [2:0]        bank0_state_o,
   output logic [2:0]        bank1_state_o
);

   localparam int BANK_BIT  = ADDR_W - 1;
   localparam int AP_BIT    = ADDR_W - 2;
   localparam int NUM_BANKS = 2;

   initial begin
      assert (ADDR_W >= 3) else $error("guard: address needs bank, flag and at least one more bit");
   end

   logic                 cke_q;
   cmd_e                 cmd;
   logic                 bank_cmd;
   bank_e                bk_state [NUM_BANKS];
   err_e                 bk_err   [NUM_BANKS];
   logic [NUM_BANKS-1:0] bk_idle, bk_burst;
   logic                 all_idle, any_burst;
   err_e                 err_next;
   logic                 unused_addr;

   assign unused_addr = ^addr[AP_BIT-1:0];

   sdram_cmd_decode i_decode (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cke   (cke),
      .cke_q (cke_q),
      .ap    (addr[AP_BIT]),
      .cmd   (cmd)
   );

   assign bank_cmd = (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_RDA) ||
                     (cmd == CMD_WR)  || (cmd == CMD_WRA) || (cmd == CMD_PRE);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (cmd == CMD_PALL) || (cmd == CMD_BST) ||
                   (bank_cmd && (addr[BANK_BIT] == 1'(b)));
      sdram_bank_track #(
         .T_RCD     (T_RCD),
         .T_RAS     (T_RAS),
         .T_RP      (T_RP),
         .BURST_LEN (BURST_LEN)
      ) i_track (
         .clk     (clk),
         .rst_n   (rst_n),
         .advance (cke),
         .hit     (hit),
         .cmd     (cmd),
         .state_o (bk_state[b]),
         .err_o   (bk_err[b]),
         .idle_o  (bk_idle[b]),
         .burst_o (bk_burst[b])
      );
   end

   assign all_idle  = &bk_idle;
   assign any_burst = |bk_burst;

   always_comb begin
      case (cmd)
         CMD_PDN:  err_next = (all_idle || any_burst) ? ERR_NONE : ERR_PDN;
         CMD_SREF: err_next = all_idle ? ERR_NONE : ERR_SREF;
         CMD_REF:  err_next = all_idle ? ERR_NONE : ERR_REF;
         CMD_MRS:  err_next = all_idle ? ERR_NONE : ERR_MRS;
         default:  err_next = (bk_err[0] != ERR_NONE) ? bk_err[0] : bk_err[1];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q      <= 1'b1;
         cmd_code_o <= 4'd0;
         err_o      <= 1'b0;
         err_code_o <= 4'd0;
      end else begin
         cke_q      <= cke;
         cmd_code_o <= cmd;
         err_o      <= (err_next != ERR_NONE);
         err_code_o <= err_next;
      end
   end

   assign bank0_state_o = bk_state[0];
   assign bank1_state_o = bk_state[1];

endmodule

// File: rtl/sdram_cmd_guard_sva.sv
module sdram_cmd_guard_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic       cke,
   input logic       bank_sel,
   input logic       err_o,
   input logic [3:0] err_code_o,
   input logic [2:0] bank0_state_o,
   input logic [2:0] bank1_state_o
);

   logic act_pins, rd_pins;
   assign act_pins = cke && !cs_n && !ras_n && cas_n && we_n;
   assign rd_pins  = cke && !cs_n && ras_n && !cas_n && we_n;

   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bank0_state_o <= 3'd4 && bank1_state_o <= 3'd4); // R2

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_pins && !bank_sel && bank0_state_o == 3'd0) |=> (bank0_state_o == 3'd1 && !err_o)); // R2

   AST_ACT_OPEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (act_pins && bank_sel && bank1_state_o == 3'd1) |=> (err_o && err_code_o == 4'd1)); // R3

   AST_RD_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pins && !bank_sel && bank0_state_o == 3'd0) |=> (err_code_o == 4'd2)); // R4

   AST_PRECH_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (bank0_state_o == 3'd4) |=> (bank0_state_o != 3'd2 && bank0_state_o != 3'd3)); // R7

   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(bank0_state_o) && $stable(bank1_state_o))); // R9

   AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o == (err_code_o != 4'd0)); // R11

endmodule

bind sdram_cmd_guard sdram_cmd_guard_sva i_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .cs_n          (cs_n),
   .ras_n         (ras_n),
   .cas_n         (cas_n),
   .we_n          (we_n),
   .cke           (cke),
   .bank_sel      (addr[ADDR_W-1]),
   .err_o         (err_o),
   .err_code_o    (err_code_o),
   .bank0_state_o (bank0_state_o),
   .bank1_state_o (bank1_state_o)
);

// File: tb/test_sdram_cmd_guard.sv
module test_sdram_cmd_guard;

   logic        clk = 1'b0;
   logic        rst_n, cs_n, ras_n, cas_n, we_n, cke;
   logic [11:0] addr;
   logic [3:0]  cmd_code_o, err_code_o;
   logic        err_o;
   logic [2:0]  bank0_state_o, bank1_state_o;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   sdram_cmd_guard i_sdram_cmd_guard (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n          (cs_n),
      .ras_n         (ras_n),
      .cas_n         (cas_n),
      .we_n          (we_n),
      .cke           (cke),
      .addr          (addr),
      .cmd_code_o    (cmd_code_o),
      .err_o         (err_o),
      .err_code_o    (err_code_o),
      .bank0_state_o (bank0_state_o),
      .bank1_state_o (bank1_state_o)
   );

   task automatic chk(string tag, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   // drive at a falling edge, return at the next falling edge (outputs then show the result)
   task automatic step(logic c, logic r, logic ca, logic w, logic k, logic [11:0] a);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; addr = a;
      @(negedge clk);
   endtask

   task automatic nop();                step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h0); endtask
   task automatic act(logic b);         step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, {b, 11'h05a}); endtask
   task automatic rd(logic b, logic ap); step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {b, ap, 10'h010}); endtask
   task automatic wr(logic b, logic ap); step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, {b, ap, 10'h020}); endtask
   task automatic pre(logic b, logic al); step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, {b, al, 10'h0}); endtask
   task automatic cke_low();            step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h0); endtask

   task automatic t_reset();
      chk("R1 reset cmd", cmd_code_o, 0);
      chk("R11 reset err", err_o, 0);
      chk("R2 reset bank0", bank0_state_o, 0);
      chk("R2 reset bank1", bank1_state_o, 0);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'h0);   // deselected activate pattern
      chk("R1 deselect cmd", cmd_code_o, 0);
      chk("R1 deselect bank0", bank0_state_o, 0);
   endtask

   task automatic t_act_rules();
      act(1'b0);
      chk("R2 act cmd", cmd_code_o, 1);
      chk("R2 act opens", bank0_state_o, 1);
      chk("R11 act no err", err_o, 0);
      rd(1'b0, 1'b0);
      chk("R5 early read code", err_code_o, 3);
      chk("R11 early read pulse", err_o, 1);
      chk("R5 early read ignored", bank0_state_o, 1);
      act(1'b0);
      chk("R3 open act code", err_code_o, 1);
      chk("R3 open act state", bank0_state_o, 1);
      rd(1'b0, 1'b0);
      chk("R5 read at limit", bank0_state_o, 2);
      chk("R1 read cmd", cmd_code_o, 2);
      chk("R11 pulse one cycle", err_o, 0);
      nop(); nop(); nop();
      chk("R8 burst last cycle", bank0_state_o, 2);
      nop();
      chk("R8 burst ends open", bank0_state_o, 1);
      pre(1'b0, 1'b0);
      chk("R6 precharge accepted", bank0_state_o, 4);
      chk("R1 pre cmd", cmd_code_o, 6);
      nop();
      chk("R7 still precharging", bank0_state_o, 4);
      nop();
      chk("R7 idle after T_RP", bank0_state_o, 0);
   endtask

   task automatic t_idle_access();
      rd(1'b1, 1'b0);
      chk("R4 read idle code", err_code_o, 2);
      wr(1'b1, 1'b0);
      chk("R4 write idle code", err_code_o, 2);
      chk("R1 write cmd", cmd_code_o, 4);
      chk("R4 bank stays idle", bank1_state_o, 0);
   endtask

   task automatic t_ras_busy();
      act(1'b1);
      nop(); nop();
      pre(1'b1, 1'b0);
      chk("R6 early pre code", err_code_o, 4);
      chk("R6 early pre ignored", bank1_state_o, 1);
      pre(1'b1, 1'b0);
      chk("R6 pre at limit", bank1_state_o, 4);
      act(1'b1);
      chk("R7 busy act code", err_code_o, 5);
      act(1'b1);
      chk("R7 act at T_RP", bank1_state_o, 1);
      chk("R7 act at T_RP no err", err_o, 0);
      nop(); nop(); nop();
      pre(1'b0, 1'b1);
      chk("R6 all-bank cmd", cmd_code_o, 7);
      chk("R6 all-bank bank1", bank1_state_o, 4);
      chk("R6 all-bank bank0 idle", bank0_state_o, 0);
      chk("R6 pre idle no err", err_o, 0);
      nop(); nop();
      chk("R7 bank1 idle again", bank1_state_o, 0);
   endtask

   task automatic t_autopre();
      act(1'b0);
      nop();
      wr(1'b0, 1'b1);
      chk("R1 write-ap cmd", cmd_code_o, 5);
      chk("R8 writing", bank0_state_o, 3);
      nop(); nop(); nop();
      chk("R8 write last cycle", bank0_state_o, 3);
      nop();
      chk("R8 auto precharge", bank0_state_o, 4);
      nop();
      chk("R8 auto precharge hold", bank0_state_o, 4);
      nop();
      chk("R8 auto precharge idle", bank0_state_o, 0);
   endtask

   task automatic t_bst();
      act(1'b1);
      nop();
      rd(1'b1, 1'b0);
      nop();
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h0);
      chk("R1 burst stop cmd", cmd_code_o, 11);
      chk("R8 burst stop opens", bank1_state_o, 1);
   endtask

   task automatic t_power();
      // bank1 open, not bursting
      cke_low();
      chk("R9 pdn cmd", cmd_code_o, 12);
      chk("R9 pdn not idle code", err_code_o, 6);
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000);   // activate pattern while CKE low
      chk("R9 frozen cmd", cmd_code_o, 0);
      chk("R9 frozen bank0", bank0_state_o, 0);
      nop();
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0);
      chk("R10 refresh busy code", err_code_o, 8);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h0);
      chk("R10 mode load busy code", err_code_o, 9);
      chk("R1 mode load cmd", cmd_code_o, 10);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0);
      chk("R10 self-refresh busy code", err_code_o, 7);
      nop();
      // clock suspend during a read burst
      rd(1'b1, 1'b0);
      cke_low();
      chk("R9 suspend cmd", cmd_code_o, 12);
      chk("R9 suspend legal", err_o, 0);
      cke_low(); cke_low(); cke_low(); cke_low();
      chk("R9 suspend holds burst", bank1_state_o, 2);
      nop(); nop(); nop();
      chk("R9 burst resumes", bank1_state_o, 2);
      nop();
      chk("R9 burst count kept", bank1_state_o, 1);
      pre(1'b1, 1'b0);
      nop(); nop();
      chk("R7 bank1 idle", bank1_state_o, 0);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0);
      chk("R10 refresh cmd", cmd_code_o, 8);
      chk("R10 refresh idle ok", err_o, 0);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0);
      chk("R10 self-refresh cmd", cmd_code_o, 9);
      chk("R10 self-refresh ok", err_o, 0);
      cke_low();
      chk("R9 held low nop", cmd_code_o, 0);
      nop();
      cke_low();
      chk("R9 idle pdn cmd", cmd_code_o, 12);
      chk("R9 idle pdn ok", err_o, 0);
      nop();
   endtask

   initial begin
      rst_n = 1'b0;
      cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1; addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_act_rules();
      t_idle_access();
      t_ras_busy();
      t_autopre();
      t_bst();
      t_power();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule